// File: doc/BRIEF.md
# Programmable Periodic Timebase Interrupt Generator

This block divides a module clock by one of sixteen power-of-two tap values and raises a sticky event flag each time the selected period elapses. A 3-bit rate code picks one of eight taps. A range bit multiplies the chosen tap by 128. The taps are not evenly spaced: they descend in uneven steps as the code rises. The resulting interrupt period is the tap value divided by the module clock frequency. For example, code 011 in the low range with a 4.9152 MHz clock gives 128 clocks, roughly 26 µs.

Software sets the rate code while the block is disabled, then turns it on. After that it services the flag by strobing an acknowledge. The flag drives an interrupt request that is gated by an interrupt-enable bit.

Two low-power indications shape the behaviour. While the wait input is high, the counter keeps running but acknowledge strobes are ignored. While the stop input is high, the counter runs only if the clock-kept-in-stop configuration bit is set; otherwise it holds its count. With the clock kept in stop, the request still asserts, so the block can serve as a periodic wake-up source.

Top module: `tbase_gen`

## Requirements
- R1: After synchronous reset, `flag` and `irq` are both 0.
- R2: With `range_hi`=0, rate codes 0 through 7 select periods of 32768, 8192, 2048, 128, 64, 32, 16 and 8 clocks. The first `flag` rise comes at the clock edge that is exactly one period after the first enabled edge.
- R3: With `range_hi`=1, each code's period is 128 times its low-range period (code 7 gives 1024, code 5 gives 4096).
- R4: While the block stays enabled and active, consecutive terminal counts are spaced exactly one period apart.
- R5: Clearing `tb_en` returns the counter to zero. The first flag after re-enabling therefore comes one full period after the re-enable.
- R6: `flag` stays set until an acknowledge strobe. The strobe clears it at the next edge.
- R7: If a terminal count and an acknowledge occur at the same edge, `flag` stays set.
- R8: `irq` is 1 exactly when `flag` is 1 and `irq_en` is 1.
- R9: While `wait_mode` is 1, the counter keeps running and `flag_ack` has no effect on `flag`.
- R10: While `stop_mode` is 1 and `clk_in_stop` is 0, the counter holds its value. Each such cycle delays the next flag by one clock.
- R11: While `stop_mode` and `clk_in_stop` are both 1, the counter runs normally. The resulting flag raises `irq` when `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| tb_en | input | 1 | Enables counting; when low, clears the counter and captures the rate selection |
| rate_sel | input | 3 | Tap code, change only while `tb_en` is 0 |
| range_hi | input | 1 | 1 selects the upper range (taps ×128) |
| irq_en | input | 1 | Interrupt request enable |
| flag_ack | input | 1 | Strobe that clears the flag |
| wait_mode | input | 1 | Wait-mode indication; blocks acknowledges |
| stop_mode | input | 1 | Stop-mode indication |
| clk_in_stop | input | 1 | 1 keeps the counter running in stop mode |
| flag | output | 1 | Sticky period-elapsed flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench predicts the exact edge of every flag rise from the tap table and compares it against the design. A wrong tap entry, a missing ×128 scaling or an off-by-one terminal compare would each shift a rise by a measurable number of clocks. Disable-then-enable partway through a period targets a counter that is not cleared, which would deliver the flag early. Stop without clock keep-alive targets a counter that ignores the freeze, which would flag early, and acknowledges during wait target a flag that clears anyway. A design that lets an acknowledge win over a simultaneous terminal count would drop an event and show `flag` low.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
   localparam int unsigned TAP_SEL_W    = 3;
   localparam int unsigned TAP_NCODE    = 1 << TAP_SEL_W;
   localparam int unsigned TAP_MAX_LOG2 = 15;

   // log2 of the tap divisor for a code; upper range adds a shift
   function automatic int unsigned tap_log2(input logic [TAP_SEL_W-1:0] code,
                                            input logic                 upper,
                                            input int unsigned          shift);
      int unsigned base;
      case (code)
         3'd0:    base = 15;
         3'd1:    base = 13;
         3'd2:    base = 11;
         3'd3:    base = 7;
         3'd4:    base = 6;
         3'd5:    base = 5;
         3'd6:    base = 4;
         default: base = 3;
      endcase
      return base + (upper ? shift : 0);
   endfunction
endpackage

// File: rtl/tbase_rate_decode.sv
module tbase_rate_decode
   import tbase_pkg::*;
#(
   parameter int unsigned CNT_W       = 22,
   parameter int unsigned RANGE_SHIFT = 7
) (
   input  logic [TAP_SEL_W-1:0] code,
   input  logic                 upper,
   output logic [CNT_W-1:0]     term
);
   logic [CNT_W-1:0] lo_tbl [TAP_NCODE];
   logic [CNT_W-1:0] hi_tbl [TAP_NCODE];

   for (genvar g = 0; g < TAP_NCODE; g++) begin : g_tap
      assign lo_tbl[g] = CNT_W'((64'd1 << tap_log2(TAP_SEL_W'(g), 1'b0, RANGE_SHIFT)) - 64'd1);
      assign hi_tbl[g] = CNT_W'((64'd1 << tap_log2(TAP_SEL_W'(g), 1'b1, RANGE_SHIFT)) - 64'd1);
   end

   assign term = upper ? hi_tbl[code] : lo_tbl[code];
endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
   parameter int unsigned CNT_W = 22
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             active,
   input  logic [CNT_W-1:0] term,
   output logic             tick
);
   logic [CNT_W-1:0] cnt;
   logic             at_term;

   assign at_term = (cnt == term);
   assign tick    = en && active && at_term;

   always_ff @(posedge clk) begin
      if (rst || !en)
         cnt <= '0;
      else if (active)
         cnt <= at_term ? '0 : cnt + 1'b1;
   end

   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
      !en |=> (cnt == '0)); // R5
   AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (en && !active && $past(en)) |=> $stable(cnt)); // R10
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      en |-> (cnt <= term)); // R4
   AST_CNT_STEPS: assert property (@(posedge clk) disable iff (rst)
      (en && active && !at_term) |=> (cnt == $past(cnt) + 1'b1)); // R11
endmodule

// File: rtl/tbase_flag.sv
module tbase_flag (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic ack,
   input  logic ack_block,
   input  logic irq_en,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (rst)
         flag <= 1'b0;
      else if (tick)
         flag <= 1'b1;
      else if (ack && !ack_block)
         flag <= 1'b0;
   end

   assign irq = flag & irq_en;

   AST_TICK_WINS: assert property (@(posedge clk) disable iff (rst)
      tick |=> flag); // R7
   AST_ACK_BLOCKED: assert property (@(posedge clk) disable iff (rst)
      (flag && ack && ack_block) |=> flag); // R9
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (flag && ack && !ack_block && !tick) |=> !flag); // R6
endmodule

// File: rtl/tbase_gen.sv
module tbase_gen
   import tbase_pkg::*;
#(
   parameter int unsigned CNT_W       = 22,
   parameter int unsigned RANGE_SHIFT = 7
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tb_en,
   input  logic [2:0] rate_sel,
   input  logic       range_hi,
   input  logic       irq_en,
   input  logic       flag_ack,
   input  logic       wait_mode,
   input  logic       stop_mode,
   input  logic       clk_in_stop,
   output logic       flag,
   output logic       irq
);
   localparam int unsigned NEED_W = TAP_MAX_LOG2 + RANGE_SHIFT;

   if (CNT_W < NEED_W) begin : g_chk_w
      $error("tbase_gen: CNT_W too small for largest tap");
   end
   if (RANGE_SHIFT > 32) begin : g_chk_s
      $error("tbase_gen: RANGE_SHIFT out of range");
   end

   logic [TAP_SEL_W-1:0] sel_q;
   logic                 upper_q;
   logic [CNT_W-1:0]     term;
   logic                 active;
   logic                 tick;

   // selection captured only while disabled
   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q   <= '0;
         upper_q <= 1'b0;
      end else if (!tb_en) begin
         sel_q   <= rate_sel;
         upper_q <= range_hi;
      end
   end

   assign active = !(stop_mode && !clk_in_stop);

   tbase_rate_decode #(.CNT_W(CNT_W), .RANGE_SHIFT(RANGE_SHIFT)) dec_i (
      .code  (sel_q),
      .upper (upper_q),
      .term  (term)
   );

   tbase_prescaler #(.CNT_W(CNT_W)) pre_i (
      .clk    (clk),
      .rst    (rst),
      .en     (tb_en),
      .active (active),
      .term   (term),
      .tick   (tick)
   );

   tbase_flag flg_i (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .ack       (flag_ack),
      .ack_block (wait_mode),
      .irq_en    (irq_en),
      .flag      (flag),
      .irq       (irq)
   );

   AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
      $rose(flag) |-> $past(tick)); // R4
endmodule

// File: tb/tbase_gen_tb_top.sv
`timescale 1ns/1ps
module tbase_gen_tb_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tb_en = 1'b0, range_hi = 1'b0, irq_en = 1'b0, flag_ack = 1'b0;
   logic wait_mode = 1'b0, stop_mode = 1'b0, clk_in_stop = 1'b0;
   logic [2:0] rate_sel = 3'd0;
   logic flag, irq;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   int exp_q[$];
   string tag_q[$];
   logic prev_flag = 1'b0;

   int lo_div[8] = '{32768, 8192, 2048, 128, 64, 32, 16, 8};

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tbase_gen dut_i (
      .clk(clk), .rst(rst), .tb_en(tb_en), .rate_sel(rate_sel), .range_hi(range_hi),
      .irq_en(irq_en), .flag_ack(flag_ack), .wait_mode(wait_mode), .stop_mode(stop_mode),
      .clk_in_stop(clk_in_stop), .flag(flag), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int div_of(input int code, input bit hi);
      return hi ? lo_div[code] * 128 : lo_div[code];   // R3 scaling
   endfunction

   // scoreboard monitor: compare each flag rise with the predicted edge
   always @(negedge clk) begin
      if (!rst) begin
         if (flag && !prev_flag) begin
            if (exp_q.size() == 0) chk(1'b0, "R4 unexpected flag", cyc, -1);
            else begin
               int e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(cyc == e, t, cyc, e);
            end
         end
         prev_flag <= flag;
      end
   end

   task automatic push(input int t, input string tag);
      exp_q.push_back(t);
      tag_q.push_back(tag);
   endtask

   task automatic go_to(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic pulse_ack();
      flag_ack = 1'b1;
      @(negedge clk);
      flag_ack = 1'b0;
   endtask

   task automatic setup(input int code, input bit hi);
      tb_en = 1'b0;
      rate_sel = 3'(code);
      range_hi = hi;
      repeat (2) @(negedge clk);
   endtask

   task automatic run_code(input int code, input bit hi, input int n, input bit ie, input string tag);
      int k, d;
      setup(code, hi);
      irq_en = ie;
      d = div_of(code, hi);
      tb_en = 1'b1;
      k = cyc;
      for (int i = 1; i <= n; i++) push(k + i * d, (i == 1) ? tag : "R4 period");
      for (int i = 1; i <= n; i++) begin
         go_to(k + i * d);
         chk(irq == ie, "R8 irq gating", irq, ie);
         pulse_ack();
         chk(flag == 1'b0, "R6 ack clears", flag, 0);
      end
      tb_en = 1'b0;
   endtask

   initial begin
      int k;
      repeat (4) @(negedge clk);
      chk(flag == 1'b0, "R1 flag reset", flag, 0);
      chk(irq == 1'b0, "R1 irq reset", irq, 0);
      rst = 1'b0;
      @(negedge clk);

      run_code(7, 1'b0, 3, 1'b1, "R2 code7 low");
      run_code(6, 1'b0, 2, 1'b0, "R2 code6 low");
      run_code(3, 1'b0, 2, 1'b1, "R2 code3 low");
      run_code(4, 1'b0, 1, 1'b0, "R2 code4 low");
      run_code(0, 1'b0, 1, 1'b1, "R2 code0 low");
      run_code(7, 1'b1, 2, 1'b1, "R3 code7 high");
      run_code(5, 1'b1, 1, 1'b0, "R3 code5 high");

      // R5: disable mid-period restarts the count
      setup(7, 1'b0);
      tb_en = 1'b1; k = cyc;
      go_to(k + 5);
      chk(flag == 1'b0, "R5 no early flag", flag, 0);
      tb_en = 1'b0;
      go_to(k + 7);
      tb_en = 1'b1; k = cyc;
      push(k + 8, "R5 full period after re-enable");
      go_to(k + 8);
      pulse_ack();
      tb_en = 1'b0;

      // R7: terminal count coincides with acknowledge
      setup(6, 1'b0);
      tb_en = 1'b1; k = cyc;
      push(k + 16, "R2 code6 before coincidence");
      go_to(k + 31);
      flag_ack = 1'b1;
      @(negedge clk);
      flag_ack = 1'b0;
      chk(flag == 1'b1, "R7 tick beats ack", flag, 1);
      pulse_ack();
      chk(flag == 1'b0, "R6 ack after coincidence", flag, 0);
      push(k + 48, "R4 period after coincidence");
      go_to(k + 48);
      pulse_ack();
      tb_en = 1'b0;

      // R9: wait mode runs counter, blocks ack
      setup(7, 1'b0);
      wait_mode = 1'b1;
      tb_en = 1'b1; k = cyc;
      push(k + 8, "R9 counter runs in wait");
      go_to(k + 8);
      pulse_ack();
      chk(flag == 1'b1, "R9 ack ignored in wait", flag, 1);
      wait_mode = 1'b0;
      pulse_ack();
      chk(flag == 1'b0, "R6 ack after wait", flag, 0);
      push(k + 16, "R9 period kept through wait");
      go_to(k + 16);
      pulse_ack();
      tb_en = 1'b0;

      // R10: stop without clock keep-alive freezes the count
      setup(7, 1'b0);
      clk_in_stop = 1'b0;
      tb_en = 1'b1; k = cyc;
      go_to(k + 3);
      stop_mode = 1'b1;
      go_to(k + 23);
      chk(flag == 1'b0, "R10 no flag while frozen", flag, 0);
      stop_mode = 1'b0;
      push(k + 28, "R10 delayed by frozen cycles");
      go_to(k + 28);
      pulse_ack();
      tb_en = 1'b0;

      // R11: stop with clock kept runs and requests
      setup(7, 1'b0);
      clk_in_stop = 1'b1;
      irq_en = 1'b1;
      stop_mode = 1'b1;
      tb_en = 1'b1; k = cyc;
      push(k + 8, "R11 runs in stop");
      go_to(k + 8);
      chk(irq == 1'b1, "R11 wake request", irq, 1);
      pulse_ack();
      stop_mode = 1'b0;
      tb_en = 1'b0;

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R4 missing flags", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(5.0 * 190000);
      chk(1'b0, "R4 watchdog expired", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule